// File: doc/BRIEF.md
# Stop-Mode Standby Sequencer

This block sequences a small microcontroller into and out of its deepest low-power state. A single-cycle request from the CPU core moves it from normal operation into a stopped state. In the stopped state it turns off the main oscillator and the frequency-multiplier output, and it gates the CPU clock. It also gates each peripheral clock according to the count clock that peripheral has selected. Peripherals fed from the subsystem clock or from an external pin can keep running. Everything that depends on the main clock is frozen. Port output latches are held throughout.

Any interrupt whose request flag is set and whose mask is clear ends the stopped state. The controller does not return straight to normal operation. It first enters a halt-wait phase: the oscillator is re-enabled, but the CPU stays stopped while a down-counter covers the oscillator's stabilization time. That time is chosen by a 3-bit select. If an unmasked interrupt is already pending when the request arrives, the controller goes straight to halt-wait and never stays stopped.

The stabilization counter runs on the same clock as the state register, which in the chip is the restarting main oscillator.

Top module: `stop_standby_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mode` is RUN (2'b00). All clock enables are 1 and `port_hold` is 0.
- R2: In RUN with no unmasked interrupt pending, a `stop_req` pulse makes `mode` STOP (2'b01) after the next clock edge. `stop_req` has no effect while `mode` is STOP or HALT_WAIT, and the code 2'b11 never appears.
- R3: While `mode` is STOP, `main_osc_en`, `mult_en` and `cpu_clk_en` are 0 and `port_hold` is 1.
- R4: In STOP, a set bit of `irq_flag` whose `irq_mask` bit is 0 moves `mode` to HALT_WAIT (2'b10) after the next edge. Set flags whose mask bit is 1 leave `mode` in STOP.
- R5: A `stop_req` that arrives in RUN while an unmasked interrupt is pending moves `mode` straight to HALT_WAIT after the next edge, without passing through STOP.
- R6: HALT_WAIT lasts exactly N cycles and is then followed by RUN. N is 2^STAB_EXP0 for select 0, 2^STAB_EXP1 for 1, 2^STAB_EXP2 for 2, and 2^STAB_EXP3 for 3 to 7. The defaults are 12, 15, 17 and 19. `stab_sel` is sampled at the edge that enters HALT_WAIT. During HALT_WAIT, `main_osc_en`=1, `mult_en`=0, `cpu_clk_en`=0 and `port_hold`=1.
- R7: Whenever `mode` is not RUN, all of `fixed_clk_en` is 0. Bit 0 is the watchdog, bit 1 the 16-bit timer, bit 2 the A/D converter and bit 3 the multiplier.
- R8: When `mode` is not RUN, the enable of 8-bit timer k follows its 2-bit field `tmr_src[2k+1:2k]`:
  - 00 (main clock): 0.
  - 01 (subsystem clock): equals `sub_osc_on`.
  - 10 (external input): 1.
  - 11 (cascade): equals the enable of timer k+1, and is 0 for the highest timer.
- R9: When `mode` is not RUN, `subp_clk_en[i]` is 1 only if `subp_sel[i]` is 1 (subsystem clock chosen) and `sub_osc_on` is 1. The bits are the watch timer, the display controller and the remote-control receiver.
- R10: In RUN, every bit of `tmr8_clk_en` and `subp_clk_en` is 1, whatever the selects are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (main oscillator domain) |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| irq_flag | input | NUM_IRQ | Interrupt request flags |
| irq_mask | input | NUM_IRQ | Interrupt masks, 1 = masked |
| stab_sel | input | 3 | Stabilization time select |
| tmr_src | input | 2*NUM_T8 | Count-clock source per 8-bit timer |
| subp_sel | input | NUM_SUBP | Subsystem clock chosen, per sub-clock peripheral |
| sub_osc_on | input | 1 | Subsystem oscillator is running |
| main_osc_en | output | 1 | Main oscillator enable |
| mult_en | output | 1 | Frequency multiplier output enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| port_hold | output | 1 | Hold port output latches |
| fixed_clk_en | output | 4 | Watchdog, 16-bit timer, A/D converter and multiplier clock enables |
| tmr8_clk_en | output | NUM_T8 | 8-bit timer clock enables |
| subp_clk_en | output | NUM_SUBP | Sub-clock peripheral enables |
| mode | output | 2 | RUN=00, STOP=01, HALT_WAIT=10 |

## Verification
The following are checked on every cycle:
- the legal mode codes and the allowed transitions (RUN only leaves on a request, STOP only leaves on an unmasked interrupt, HALT_WAIT never returns to STOP);
- the CPU and oscillator enables in each mode;
- the fixed-group gating;
- the all-on rule in RUN;
- an upper bound on the length of HALT_WAIT.

Other behaviours can only be shown by the bench's scenarios:
- the exact HALT_WAIT length for each select code, including the reserved codes;
- that `stab_sel` is sampled at entry;
- that a pending interrupt short-circuits entry;
- how the cascade chain and the subsystem-clock conditions resolve for each peripheral.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_STOP = 2'b01,
        MODE_HALT = 2'b10
    } stby_mode_e;

    typedef enum logic [1:0] {
        TSRC_MAIN = 2'b00,
        TSRC_SUB  = 2'b01,
        TSRC_EXT  = 2'b10,
        TSRC_CASC = 2'b11
    } tsrc_e;

    localparam int FIX_WDT   = 0;
    localparam int FIX_T16   = 1;
    localparam int FIX_ADC   = 2;
    localparam int FIX_MUL   = 3;
    localparam int FIXED_W   = 4;
    localparam int SEL_W     = 3;

    typedef struct packed {
        logic osc_en;
        logic mult_en;
        logic cpu_en;
        logic hold;
    } core_ctl_t;

    function automatic core_ctl_t ctl_for_mode(stby_mode_e m);
        core_ctl_t c;
        c.osc_en  = (m != MODE_STOP);
        c.mult_en = (m == MODE_RUN);
        c.cpu_en  = (m == MODE_RUN);
        c.hold    = (m != MODE_RUN);
        return c;
    endfunction

    function automatic int unsigned pick_exp(logic [SEL_W-1:0] sel,
                                             int unsigned e0, int unsigned e1,
                                             int unsigned e2, int unsigned e3);
        case (sel)
            3'd0:    return e0;
            3'd1:    return e1;
            3'd2:    return e2;
            default: return e3;
        endcase
    endfunction

endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       stab_done,
    output stby_mode_e mode,
    output logic       stab_load
);

    stby_mode_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        stab_load = 1'b0;
        case (state_q)
            MODE_RUN: begin
                if (stop_req) begin
                    if (wake) begin
                        state_d   = MODE_HALT;
                        stab_load = 1'b1;
                    end else begin
                        state_d   = MODE_STOP;
                    end
                end
            end
            MODE_STOP: begin
                if (wake) begin
                    state_d   = MODE_HALT;
                    stab_load = 1'b1;
                end
            end
            MODE_HALT: begin
                if (stab_done) state_d = MODE_RUN;
            end
            default: state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_RUN;
        else     state_q <= state_d;
    end

    assign mode = state_q;

endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt
    import stby_pkg::*;
#(
    parameter int unsigned STAB_EXP0 = 12,
    parameter int unsigned STAB_EXP1 = 15,
    parameter int unsigned STAB_EXP2 = 17,
    parameter int unsigned STAB_EXP3 = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             in_halt,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    localparam int unsigned CNT_W = (STAB_EXP3 < 1) ? 1 : STAB_EXP3;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    int unsigned      exp_sel;

    always_comb begin
        exp_sel  = pick_exp(sel, STAB_EXP0, STAB_EXP1, STAB_EXP2, STAB_EXP3);
        load_val = CNT_W'((64'd1 << exp_sel) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst)                         cnt_q <= '0;
        else if (load)                   cnt_q <= load_val;
        else if (in_halt && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/stby_periph_gate.sv
module stby_periph_gate
    import stby_pkg::*;
#(
    parameter int NUM_T8   = 3,
    parameter int NUM_SUBP = 3
) (
    input  logic                  is_run,
    input  logic [2*NUM_T8-1:0]   tmr_src,
    input  logic [NUM_SUBP-1:0]   subp_sel,
    input  logic                  sub_osc_on,
    output logic [FIXED_W-1:0]    fixed_clk_en,
    output logic [NUM_T8-1:0]     tmr8_clk_en,
    output logic [NUM_SUBP-1:0]   subp_clk_en
);

    logic [NUM_T8-1:0] t8_stop_on;

    always_comb begin
        logic casc_in;
        t8_stop_on = '0;
        for (int k = NUM_T8 - 1; k >= 0; k--) begin
            casc_in = (k == NUM_T8 - 1) ? 1'b0 : t8_stop_on[(k + 1) % NUM_T8];
            case (tsrc_e'(tmr_src[2*k +: 2]))
                TSRC_SUB:  t8_stop_on[k] = sub_osc_on;
                TSRC_EXT:  t8_stop_on[k] = 1'b1;
                TSRC_CASC: t8_stop_on[k] = casc_in;
                default:   t8_stop_on[k] = 1'b0;
            endcase
        end
    end

    assign fixed_clk_en = is_run ? {FIXED_W{1'b1}} : {FIXED_W{1'b0}};

    assign tmr8_clk_en = is_run ? {NUM_T8{1'b1}} : t8_stop_on;

    generate
        for (genvar i = 0; i < NUM_SUBP; i++) begin : g_subp
            assign subp_clk_en[i] = is_run | (subp_sel[i] & sub_osc_on);
        end
    endgenerate

endmodule

// File: rtl/stop_standby_ctrl.sv
module stop_standby_ctrl
    import stby_pkg::*;
#(
    parameter int          NUM_IRQ   = 8,
    parameter int          NUM_T8    = 3,
    parameter int          NUM_SUBP  = 3,
    parameter int unsigned STAB_EXP0 = 12,
    parameter int unsigned STAB_EXP1 = 15,
    parameter int unsigned STAB_EXP2 = 17,
    parameter int unsigned STAB_EXP3 = 19
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stop_req,
    input  logic [NUM_IRQ-1:0]    irq_flag,
    input  logic [NUM_IRQ-1:0]    irq_mask,
    input  logic [2:0]            stab_sel,
    input  logic [2*NUM_T8-1:0]   tmr_src,
    input  logic [NUM_SUBP-1:0]   subp_sel,
    input  logic                  sub_osc_on,
    output logic                  main_osc_en,
    output logic                  mult_en,
    output logic                  cpu_clk_en,
    output logic                  port_hold,
    output logic [3:0]            fixed_clk_en,
    output logic [NUM_T8-1:0]     tmr8_clk_en,
    output logic [NUM_SUBP-1:0]   subp_clk_en,
    output logic [1:0]            mode
);

    stby_mode_e mode_s;
    logic       wake;
    logic       stab_load;
    logic       stab_done;
    core_ctl_t  ctl;

    assign wake = |(irq_flag & ~irq_mask);

    stby_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_req),
        .wake      (wake),
        .stab_done (stab_done),
        .mode      (mode_s),
        .stab_load (stab_load)
    );

    stby_stab_cnt #(
        .STAB_EXP0 (STAB_EXP0),
        .STAB_EXP1 (STAB_EXP1),
        .STAB_EXP2 (STAB_EXP2),
        .STAB_EXP3 (STAB_EXP3)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (stab_load),
        .in_halt (mode_s == MODE_HALT),
        .sel     (stab_sel),
        .done    (stab_done)
    );

    stby_periph_gate #(
        .NUM_T8   (NUM_T8),
        .NUM_SUBP (NUM_SUBP)
    ) u_gate (
        .is_run       (mode_s == MODE_RUN),
        .tmr_src      (tmr_src),
        .subp_sel     (subp_sel),
        .sub_osc_on   (sub_osc_on),
        .fixed_clk_en (fixed_clk_en),
        .tmr8_clk_en  (tmr8_clk_en),
        .subp_clk_en  (subp_clk_en)
    );

    assign ctl         = ctl_for_mode(mode_s);
    assign main_osc_en = ctl.osc_en;
    assign mult_en     = ctl.mult_en;
    assign cpu_clk_en  = ctl.cpu_en;
    assign port_hold   = ctl.hold;
    assign mode        = mode_s;

endmodule

// File: rtl/stby_chk.sv
module stby_chk #(
    parameter int          NUM_IRQ   = 8,
    parameter int          NUM_T8    = 3,
    parameter int          NUM_SUBP  = 3,
    parameter int unsigned STAB_EXP3 = 19
) (
    input logic                clk,
    input logic                rst,
    input logic                stop_req,
    input logic [NUM_IRQ-1:0]  irq_flag,
    input logic [NUM_IRQ-1:0]  irq_mask,
    input logic                main_osc_en,
    input logic                mult_en,
    input logic                cpu_clk_en,
    input logic [3:0]          fixed_clk_en,
    input logic [NUM_T8-1:0]   tmr8_clk_en,
    input logic [NUM_SUBP-1:0] subp_clk_en,
    input logic [1:0]          mode
);

    localparam logic [1:0]  M_RUN   = 2'b00;
    localparam logic [1:0]  M_STOP  = 2'b01;
    localparam logic [1:0]  M_HALT  = 2'b10;
    localparam logic [63:0] HALT_MAX = 64'd1 << STAB_EXP3;

    logic        pend;
    logic [63:0] halt_run;

    assign pend = |(irq_flag & ~irq_mask);

    always_ff @(posedge clk) begin
        if (rst)                 halt_run <= '0;
        else if (mode == M_HALT) halt_run <= halt_run + 64'd1;
        else                     halt_run <= '0;
    end

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RUN && !stop_req) |=> mode == M_RUN);

    // R3
    stop_clocks_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_STOP) |-> (!main_osc_en && !mult_en && !cpu_clk_en));

    // R6
    cpu_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != M_RUN) |-> !cpu_clk_en);

    // R4
    masked_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_STOP && !pend) |=> mode == M_STOP);

    // R4
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_STOP && pend) |=> mode == M_HALT);

    // R6
    halt_no_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_HALT) |=> mode != M_STOP);

    // R6
    halt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        halt_run <= HALT_MAX);

    // R7
    fixed_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != M_RUN) |-> fixed_clk_en == 4'b0000);

    // R10
    run_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RUN) |-> (&tmr8_clk_en && &subp_clk_en && &fixed_clk_en && main_osc_en));

endmodule

bind stop_standby_ctrl stby_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_T8    (NUM_T8),
    .NUM_SUBP  (NUM_SUBP),
    .STAB_EXP3 (STAB_EXP3)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_req     (stop_req),
    .irq_flag     (irq_flag),
    .irq_mask     (irq_mask),
    .main_osc_en  (main_osc_en),
    .mult_en      (mult_en),
    .cpu_clk_en   (cpu_clk_en),
    .fixed_clk_en (fixed_clk_en),
    .tmr8_clk_en  (tmr8_clk_en),
    .subp_clk_en  (subp_clk_en),
    .mode         (mode)
);

// File: tb/stop_standby_ctrl_bench.sv
`timescale 1ns/1ps
module stop_standby_ctrl_bench;

    localparam int NI = 8;
    localparam int NT = 3;
    localparam int NS = 3;
    localparam int E0 = 3;
    localparam int E1 = 4;
    localparam int E2 = 5;
    localparam int E3 = 6;

    localparam logic [1:0] RUN  = 2'b00;
    localparam logic [1:0] STOP = 2'b01;
    localparam logic [1:0] HALT = 2'b10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stop_req = 1'b0;
    logic [NI-1:0] irq_flag = '0;
    logic [NI-1:0] irq_mask = '1;
    logic [2:0]    stab_sel = 3'd0;
    logic [2*NT-1:0] tmr_src = '0;
    logic [NS-1:0] subp_sel = '0;
    logic          sub_osc_on = 1'b0;

    logic          main_osc_en, mult_en, cpu_clk_en, port_hold;
    logic [3:0]    fixed_clk_en;
    logic [NT-1:0] tmr8_clk_en;
    logic [NS-1:0] subp_clk_en;
    logic [1:0]    mode;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stop_standby_ctrl #(
        .NUM_IRQ(NI), .NUM_T8(NT), .NUM_SUBP(NS),
        .STAB_EXP0(E0), .STAB_EXP1(E1), .STAB_EXP2(E2), .STAB_EXP3(E3)
    ) u_stop_standby_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req),
        .irq_flag(irq_flag), .irq_mask(irq_mask), .stab_sel(stab_sel),
        .tmr_src(tmr_src), .subp_sel(subp_sel), .sub_osc_on(sub_osc_on),
        .main_osc_en(main_osc_en), .mult_en(mult_en), .cpu_clk_en(cpu_clk_en),
        .port_hold(port_hold), .fixed_clk_en(fixed_clk_en),
        .tmr8_clk_en(tmr8_clk_en), .subp_clk_en(subp_clk_en), .mode(mode)
    );

    function automatic int halt_len(logic [2:0] s);
        if (s == 3'd0) return 1 << E0;
        if (s == 3'd1) return 1 << E1;
        if (s == 3'd2) return 1 << E2;
        return 1 << E3;
    endfunction

    function automatic logic [NT-1:0] exp_t8(logic [1:0] m, logic [2*NT-1:0] src, logic sub);
        logic [NT-1:0] r;
        r = '1;
        if (m != RUN) begin
            for (int k = NT - 1; k >= 0; k--) begin
                case (src[2*k +: 2])
                    2'b01:   r[k] = sub;
                    2'b10:   r[k] = 1'b1;
                    2'b11:   r[k] = (k < NT - 1) ? r[(k + 1) % NT] : 1'b0;
                    default: r[k] = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

    // reference model of the mode sequence
    logic [1:0] m_mode = RUN;
    int         m_left = 0;
    wire        m_wake = |(irq_flag & ~irq_mask);

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= RUN;
            m_left <= 0;
        end else begin
            case (m_mode)
                RUN: if (stop_req) begin
                    if (m_wake) begin m_mode <= HALT; m_left <= halt_len(stab_sel); end
                    else m_mode <= STOP;
                end
                STOP: if (m_wake) begin m_mode <= HALT; m_left <= halt_len(stab_sel); end
                default: begin
                    if (m_left <= 1) m_mode <= RUN;
                    else m_left <= m_left - 1;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic compare_all();
        logic [NS-1:0] es;
        string rq;
        rq = (m_mode == RUN) ? "R1/R10" : (m_mode == STOP) ? "R3" : "R6";
        chk(mode == m_mode, "R2/R4/R5/R6", "mode", mode, m_mode);
        chk(main_osc_en == (m_mode != STOP), rq, "main_osc_en", main_osc_en, m_mode != STOP);
        chk(mult_en == (m_mode == RUN), rq, "mult_en", mult_en, m_mode == RUN);
        chk(cpu_clk_en == (m_mode == RUN), rq, "cpu_clk_en", cpu_clk_en, m_mode == RUN);
        chk(port_hold == (m_mode != RUN), rq, "port_hold", port_hold, m_mode != RUN);
        chk(fixed_clk_en == ((m_mode == RUN) ? 4'hF : 4'h0), "R7", "fixed_clk_en",
            fixed_clk_en, (m_mode == RUN) ? 4'hF : 4'h0);
        chk(tmr8_clk_en == exp_t8(m_mode, tmr_src, sub_osc_on), "R8", "tmr8_clk_en",
            tmr8_clk_en, exp_t8(m_mode, tmr_src, sub_osc_on));
        es = (m_mode == RUN) ? '1 : (subp_sel & {NS{sub_osc_on}});
        chk(subp_clk_en == es, "R9", "subp_clk_en", subp_clk_en, es);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
    endtask

    task automatic measure_halt(input logic [2:0] s);
        int n;
        n = 0;
        while (mode == HALT && n < 1000) begin
            n++;
            tick();
        end
        // R6: halt-wait length for the sampled select
        chk(n == halt_len(s), "R6", "halt length", n, halt_len(s));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        tick();
        tick();
        rst = 1'b0;
        tick();
        chk(mode == RUN && &fixed_clk_en && main_osc_en && !port_hold, "R1", "reset state",
            {mode, fixed_clk_en}, {RUN, 4'hF});

        // R4: masked pending flags do not wake; R8/R9 gating in STOP
        irq_flag = '1; irq_mask = '1;
        tmr_src = {2'b11, 2'b11, 2'b01};   // top cascade -> off, mid cascade -> off, t0 sub
        subp_sel = 3'b101; sub_osc_on = 1'b1;
        pulse_stop();
        for (int i = 0; i < 5; i++) tick();
        chk(mode == STOP, "R4", "masked flags keep stop", mode, STOP);

        // R2: stop_req ignored while stopped
        pulse_stop();
        tick();
        chk(mode == STOP, "R2", "stop_req in STOP", mode, STOP);

        tmr_src = {2'b10, 2'b11, 2'b11};   // ext at top, chain propagates down
        tick();
        chk(tmr8_clk_en == 3'b111, "R8", "cascade chain", tmr8_clk_en, 3'b111);
        tmr_src = {2'b00, 2'b11, 2'b10}; sub_osc_on = 1'b0;
        tick();
        chk(tmr8_clk_en == 3'b001, "R8", "main-fed top, cascade off", tmr8_clk_en, 3'b001);
        chk(subp_clk_en == 3'b000, "R9", "sub osc off", subp_clk_en, 3'b000);

        // R4: unmasked flag wakes; R6 length for select 1
        stab_sel = 3'd1;
        irq_mask = 8'hF7;
        tick();
        stab_sel = 3'd0;   // changed after entry: must not matter
        chk(mode == HALT, "R4", "wake to halt", mode, HALT);
        measure_halt(3'd1);
        chk(mode == RUN, "R6", "run after halt", mode, RUN);

        // R5: pending unmasked interrupt cancels entry
        stab_sel = 3'd5;
        pulse_stop();
        chk(mode == HALT, "R5", "direct halt", mode, HALT);
        measure_halt(3'd5);

        // R6: every select code, including reserved
        for (int s = 0; s < 8; s++) begin
            irq_mask = '1;
            stab_sel = 3'(s);
            pulse_stop();
            tick();
            pulse_stop();   // R2: ignored in STOP
            irq_mask = 8'hFE;
            tick();
            measure_halt(3'(s));
        end

        // constrained random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            stop_req   = ($urandom % 16) == 0;
            irq_flag   = (($urandom % 8) == 0) ? NI'($urandom) : '0;
            irq_mask   = NI'($urandom) | NI'($urandom);
            stab_sel   = 3'($urandom);
            tmr_src    = (2*NT)'($urandom);
            subp_sel   = NS'($urandom);
            sub_osc_on = $urandom % 2;
            tick();
        end
        stop_req = 1'b0;
        irq_flag = '0;
        for (int i = 0; i < 80; i++) tick();

        // R1: synchronous reset from a non-run state
        irq_mask = '1;
        pulse_stop();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        chk(mode == RUN && cpu_clk_en, "R1", "reset from stop", mode, RUN);

        finish_run();
    end

endmodule